// File: doc/BRIEF.md
# Read-Triggered ROM Bank Selector

This block sits on the 16-bit address bus of an 8-bit processor. It decodes each access into one of several memory or peripheral regions and raises the matching chip select. It also holds a small bank register. That register picks which 4 KB page of a larger paged ROM appears in a fixed program window. The ROM devices, RAMs and peripherals are outside the block. The block only selects them, forms the physical address of the paged ROM, and steers the read data back to the processor.

Software changes the page by reading from one of eight addresses at the top of the paged window. The low three bits of the address it reads become the new page number. That read returns the subroutine-return opcode rather than memory data, so code can simply call the trigger address and come straight back. An inspection input lets a debugger read the trigger addresses without changing the page.

Top module: `rom_bank_decoder`

## Requirements
- R1: A read in 0x0000–0x2FFF asserts `cs_from` and no other select.
- R2: A read in 0x3000–0x3FF7 asserts `cs_brom`, and `rom_paddr` equals page × 0x1000 plus address bits 11:0.
- R3: A read in 0x3FF8–0x3FFF with `inspect` low asserts `trig_rd` and loads the page register with address bits 2:0 at that clock edge. The new page applies from the next access.
- R4: A read in 0x3FF8–0x3FFF returns 0xC9 on `cpu_rdata`, whether `inspect` is high or low.
- R5: A trigger read with `inspect` high leaves the page unchanged.
- R6: After reset the page is 0.
- R7: Reads or writes in 0x4000–0x7FFF assert `cs_mram`, in 0x8000–0xBFFF assert `cs_xram`, and in 0xC000–0xDFFF assert `cs_cram`.
- R8: `scr_wr` is high only for a write to exactly 0x8000, together with `cs_xram`.
- R9: In 0xFC00–0xFCFF, address bits 7:5 pick a peripheral select. The values 0, 1, 2, 3 and 4 select `cs_per[0]` to `cs_per[4]`, and the value 6 selects `cs_per[5]`. The values 5 and 7 are unmapped.
- R10: A write anywhere in 0x0000–0x3FFF asserts no select and leaves the page unchanged.
- R11: At most one of the chip selects and `trig_rd` is high at a time, and none is high without `rd` or `wr`. A read that selects nothing returns 0xFF.
- R12: A read that asserts a chip select returns `mem_rdata` unchanged on `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Processor address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| inspect | input | 1 | When high, trigger reads do not change the page |
| mem_rdata | input | 8 | Data from the selected device |
| cpu_rdata | output | 8 | Data returned to the processor |
| cs_from | output | 1 | Fixed program ROM select |
| cs_brom | output | 1 | Paged ROM select |
| cs_mram | output | 1 | Main RAM select |
| cs_xram | output | 1 | Extra RAM select |
| cs_cram | output | 1 | Upper RAM select |
| cs_per | output | 6 | Peripheral selects |
| trig_rd | output | 1 | A page-trigger read is in progress |
| scr_wr | output | 1 | Screen-control write strobe |
| rom_paddr | output | 15 | Physical address into the paged ROM |

## Verification
The bench builds the block with its default values: eight pages of 4 KB, the return opcode 0xC9 and the fill byte 0xFF. With these values every trigger offset and every page can be reached within a few thousand accesses. Random addresses are weighted toward the trigger bytes, the paged window and the peripheral page. As a result, page switches, inspection reads, writes into ROM space and both unmapped peripheral slots occur many times. The expected page is tracked in the bench. Each paged-window read then shows the page through `rom_paddr`.

// File: rtl/rbk_pkg.sv
`timescale 1ns/1ps
package rbk_pkg;

  localparam int DATA_W  = 8;
  localparam int NUM_PER = 6;

  localparam logic [15:0] FROM_END  = 16'h2FFF;
  localparam logic [15:0] WIN_BASE  = 16'h3000;
  localparam logic [15:0] XRAM_BASE = 16'h8000;
  localparam logic [15:0] CRAM_BASE = 16'hC000;
  localparam logic [15:0] CRAM_END  = 16'hDFFF;
  localparam logic [7:0]  PER_HI    = 8'hFC;

  typedef enum logic [2:0] {
    RG_NONE, RG_FROM, RG_BROM, RG_TRIG, RG_MRAM, RG_XRAM, RG_CRAM, RG_PER
  } rbk_region_e;

  // Peripheral slot lookup: {valid, index}. Slot 5 and 7 are holes.
  function automatic logic [3:0] per_slot(input logic [2:0] sub);
    case (sub)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: per_slot = {1'b1, sub};
      3'd6:                         per_slot = {1'b1, 3'd5};
      default:                      per_slot = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/rbk_decode.sv
`timescale 1ns/1ps
module rbk_decode
  import rbk_pkg::*;
#(
  parameter int BANK_COUNT = 8,
  parameter int PAGE_BITS  = 12
) (
  input  logic [15:0]  addr,
  output rbk_region_e  region,
  output logic [2:0]   per_idx
);

  localparam logic [15:0] WIN_END   = 16'(int'(WIN_BASE) + (1 << PAGE_BITS) - 1);
  localparam logic [15:0] TRIG_BASE = 16'(int'(WIN_BASE) + (1 << PAGE_BITS) - BANK_COUNT);

  logic [3:0] slot;

  always_comb begin
    region  = RG_NONE;
    per_idx = '0;
    slot    = per_slot(addr[7:5]);
    if (addr <= FROM_END)         region = RG_FROM;
    else if (addr < TRIG_BASE)    region = RG_BROM;
    else if (addr <= WIN_END)     region = RG_TRIG;
    else if (addr < XRAM_BASE)    region = RG_MRAM;
    else if (addr < CRAM_BASE)    region = RG_XRAM;
    else if (addr <= CRAM_END)    region = RG_CRAM;
    else if (addr[15:8] == PER_HI && slot[3]) begin
      region  = RG_PER;
      per_idx = slot[2:0];
    end
  end

endmodule

// File: rtl/rbk_bank_reg.sv
`timescale 1ns/1ps
module rbk_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= load_val;
  end

endmodule

// File: rtl/rbk_rdata_mux.sv
`timescale 1ns/1ps
module rbk_rdata_mux #(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  RET_OP    = 8'hC9,
  parameter logic [7:0]  FILL_BYTE = 8'hFF
) (
  input  logic              trig,
  input  logic              hit,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata
);

  always_comb begin
    if (trig)     cpu_rdata = DATA_W'(RET_OP);
    else if (hit) cpu_rdata = mem_rdata;
    else          cpu_rdata = DATA_W'(FILL_BYTE);
  end

endmodule

// File: rtl/rom_bank_decoder.sv
`timescale 1ns/1ps
module rom_bank_decoder
  import rbk_pkg::*;
#(
  parameter int         BANK_COUNT = 8,
  parameter int         PAGE_BITS  = 12,
  parameter logic [7:0] RET_OP     = 8'hC9,
  parameter logic [7:0] FILL_BYTE  = 8'hFF
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [15:0]                           addr,
  input  logic                                  rd,
  input  logic                                  wr,
  input  logic                                  inspect,
  input  logic [7:0]                            mem_rdata,
  output logic [7:0]                            cpu_rdata,
  output logic                                  cs_from,
  output logic                                  cs_brom,
  output logic                                  cs_mram,
  output logic                                  cs_xram,
  output logic                                  cs_cram,
  output logic [5:0]                            cs_per,
  output logic                                  trig_rd,
  output logic                                  scr_wr,
  output logic [$clog2(BANK_COUNT)+PAGE_BITS-1:0] rom_paddr
);

  localparam int BANK_W  = $clog2(BANK_COUNT);
  localparam int PADDR_W = BANK_W + PAGE_BITS;

  function automatic logic [PADDR_W-1:0] page_addr(input logic [BANK_W-1:0] b,
                                                   input logic [PAGE_BITS-1:0] off);
    return {b, off};
  endfunction

  rbk_region_e       region;
  logic [2:0]        per_idx;
  logic [BANK_W-1:0] bank_q;
  logic              access;
  logic              bank_load;
  logic              any_cs;

  rbk_decode #(.BANK_COUNT(BANK_COUNT), .PAGE_BITS(PAGE_BITS)) u_dec (
    .addr    (addr),
    .region  (region),
    .per_idx (per_idx)
  );

  assign access  = rd | wr;
  // ROM and trigger regions respond to reads only
  assign cs_from = rd && (region == RG_FROM);
  assign cs_brom = rd && (region == RG_BROM);
  assign trig_rd = rd && (region == RG_TRIG);
  assign cs_mram = access && (region == RG_MRAM);
  assign cs_xram = access && (region == RG_XRAM);
  assign cs_cram = access && (region == RG_CRAM);
  assign scr_wr  = wr && (addr == XRAM_BASE);

  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    assign cs_per[i] = access && (region == RG_PER) && (per_idx == 3'(i));
  end

  assign bank_load = trig_rd && !inspect;

  rbk_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bank_load),
    .load_val (addr[BANK_W-1:0]),
    .bank     (bank_q)
  );

  assign rom_paddr = page_addr(bank_q, addr[PAGE_BITS-1:0]);

  assign any_cs = cs_from | cs_brom | cs_mram | cs_xram | cs_cram | (|cs_per);

  rbk_rdata_mux #(.DATA_W(DATA_W), .RET_OP(RET_OP), .FILL_BYTE(FILL_BYTE)) u_mux (
    .trig      (trig_rd),
    .hit       (any_cs),
    .mem_rdata (mem_rdata),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: rtl/rbk_checker.sv
`timescale 1ns/1ps
module rbk_checker #(
  parameter int         BANK_W    = 3,
  parameter int         PAGE_BITS = 12,
  parameter logic [7:0] RET_OP    = 8'hC9,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd,
  input logic                 wr,
  input logic                 inspect,
  input logic                 scr_wr,
  input logic [PAGE_BITS-1:0] addr_lo,
  input logic [7:0]           cpu_rdata,
  input logic                 cs_from,
  input logic                 cs_brom,
  input logic                 cs_mram,
  input logic                 cs_xram,
  input logic                 cs_cram,
  input logic [5:0]           cs_per,
  input logic                 trig_rd,
  input logic [BANK_W-1:0]    bank_q,
  input logic [BANK_W+PAGE_BITS-1:0] rom_paddr
);

  logic [11:0] sel;
  assign sel = {cs_from, cs_brom, cs_mram, cs_xram, cs_cram, cs_per, trig_rd};

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |-> (sel == '0) && !scr_wr);

  a_r11_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (sel == '0) |-> cpu_rdata == FILL_BYTE);

  a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rd && !inspect |=> bank_q == $past(addr_lo[BANK_W-1:0]));

  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_rd && !inspect) |=> $stable(bank_q));

  a_r4_ret_op: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rd |-> cpu_rdata == RET_OP);

  a_r2_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    cs_brom |-> rom_paddr == {bank_q, addr_lo});

  a_r10_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !rd |-> !cs_from && !cs_brom && !trig_rd);

  a_r8_scr_with_xram: assert property (@(posedge clk) disable iff (!rst_n)
    scr_wr |-> cs_xram && wr);

endmodule

bind rom_bank_decoder rbk_checker #(
  .BANK_W    ($clog2(BANK_COUNT)),
  .PAGE_BITS (PAGE_BITS),
  .RET_OP    (RET_OP),
  .FILL_BYTE (FILL_BYTE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd        (rd),
  .wr        (wr),
  .inspect   (inspect),
  .scr_wr    (scr_wr),
  .addr_lo   (addr[PAGE_BITS-1:0]),
  .cpu_rdata (cpu_rdata),
  .cs_from   (cs_from),
  .cs_brom   (cs_brom),
  .cs_mram   (cs_mram),
  .cs_xram   (cs_xram),
  .cs_cram   (cs_cram),
  .cs_per    (cs_per),
  .trig_rd   (trig_rd),
  .bank_q    (bank_q),
  .rom_paddr (rom_paddr)
);

// File: tb/rom_bank_decoder_tb.sv
`timescale 1ns/1ps
module rom_bank_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, inspect = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cs_from, cs_brom, cs_mram, cs_xram, cs_cram, trig_rd, scr_wr;
  logic [5:0]  cs_per;
  logic [14:0] rom_paddr;

  int total = 0;
  int bad   = 0;
  int mbank = 0;

  always #2.5 clk = ~clk;

  rom_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .inspect(inspect),
    .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata), .cs_from(cs_from),
    .cs_brom(cs_brom), .cs_mram(cs_mram), .cs_xram(cs_xram), .cs_cram(cs_cram),
    .cs_per(cs_per), .trig_rd(trig_rd), .scr_wr(scr_wr), .rom_paddr(rom_paddr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit order: 12 from, 11 brom, 10 mram, 9 xram, 8 cram, 7:2 per[5:0], 1 trig, 0 scr
  function automatic logic [12:0] exp_sel(input int a, input bit r, input bit w);
    logic [12:0] s = '0;
    bit acc = r || w;
    int k;
    if (r && a < 'h3000)                    s[12] = 1'b1;
    else if (r && a >= 'h3000 && a < 'h3FF8) s[11] = 1'b1;
    else if (r && a >= 'h3FF8 && a < 'h4000) s[1]  = 1'b1;
    else if (acc && a >= 'h4000 && a < 'h8000) s[10] = 1'b1;
    else if (acc && a >= 'h8000 && a < 'hC000) s[9]  = 1'b1;
    else if (acc && a >= 'hC000 && a < 'hE000) s[8]  = 1'b1;
    else if (acc && a >= 'hFC00 && a < 'hFD00) begin
      k = (a - 'hFC00) / 32;
      if (k <= 4)      s[2 + k] = 1'b1;
      else if (k == 6) s[7]     = 1'b1;
    end
    if (w && a == 'h8000) s[0] = 1'b1;
    return s;
  endfunction

  function automatic string tag_of(input int a, input bit w);
    if (a < 'h4000 && w) return "R10";
    if (a < 'h3000)      return "R1";
    if (a < 'h3FF8)      return "R2";
    if (a < 'h4000)      return "R3";
    if (a == 'h8000)     return "R8";
    if (a < 'hE000)      return "R7";
    if (a >= 'hFC00 && a < 'hFD00) return "R9";
    return "R11";
  endfunction

  task automatic acc(input int a, input bit r, input bit w, input bit ins,
                     input logic [7:0] md, input string ptag);
    logic [12:0] es, as;
    @(negedge clk);
    addr = 16'(a); rd = r; wr = w; inspect = ins; mem_rdata = md;
    #1;
    es = exp_sel(a, r, w);
    as = {cs_from, cs_brom, cs_mram, cs_xram, cs_cram, cs_per, trig_rd, scr_wr};
    chk(as == es, tag_of(a, w), int'(as), int'(es));
    if (r) begin
      if (es[1])             chk(cpu_rdata == 8'hC9, "R4", cpu_rdata, 'hC9);
      else if (|es[12:2])    chk(cpu_rdata == md, "R12", cpu_rdata, md);
      else                   chk(cpu_rdata == 8'hFF, "R11", cpu_rdata, 'hFF);
    end
    if (es[11])
      chk(rom_paddr == 15'(mbank * 4096 + a % 4096), ptag, rom_paddr, mbank * 4096 + a % 4096);
    @(posedge clk);
    if (r && a >= 'h3FF8 && a < 'h4000 && !ins) mbank = a % 8;
  endtask

  task automatic idle();
    @(negedge clk); rd = 0; wr = 0; inspect = 0; addr = '0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1;
    // reset state: no selects while idle
    chk({cs_from, cs_brom, cs_mram, cs_xram, cs_cram, cs_per, trig_rd, scr_wr} == 0, "R11", 0, 0);
    @(negedge clk); rst_n = 1'b1;
    acc('h3123, 1, 0, 0, 8'h11, "R6");
    acc('h0000, 1, 0, 0, 8'h22, "R2");
    acc('h2FFF, 1, 0, 0, 8'h33, "R2");
    // each trigger offset, then a window read showing the page
    for (int t = 0; t < 8; t++) begin
      acc('h3FF8 + t, 1, 0, 0, 8'h44, "R3");
      acc('h3FF7, 1, 0, 0, 8'h55, "R3");
      acc('h3000, 1, 0, 0, 8'h56, "R3");
    end
    // inspection read: data still C9, page unchanged
    acc('h3FFA, 1, 0, 0, 8'h00, "R3");
    acc('h3FFD, 1, 0, 1, 8'h00, "R5");
    acc('h3456, 1, 0, 0, 8'h66, "R5");
    // write into trigger and ROM ranges
    acc('h3FFC, 0, 1, 0, 8'h00, "R10");
    acc('h1000, 0, 1, 0, 8'h00, "R10");
    acc('h3800, 1, 0, 0, 8'h77, "R10");
    // RAM and screen strobe
    acc('h4000, 1, 0, 0, 8'h88, "R7");
    acc('h7FFF, 0, 1, 0, 8'h00, "R7");
    acc('h8000, 0, 1, 0, 8'h00, "R8");
    acc('h8000, 1, 0, 0, 8'h99, "R8");
    acc('h8001, 0, 1, 0, 8'h00, "R8");
    acc('hBFFF, 1, 0, 0, 8'hAA, "R7");
    acc('hC000, 0, 1, 0, 8'h00, "R7");
    acc('hDFFF, 1, 0, 0, 8'hBB, "R7");
    // peripheral slots and holes
    for (int p = 0; p < 8; p++) acc('hFC00 + p * 32 + 3, 1, 0, 0, 8'hC0 + p, "R9");
    acc('hFCA5, 0, 1, 0, 8'h00, "R9");
    acc('hE000, 1, 0, 0, 8'h12, "R11");
    acc('hFBFF, 1, 0, 0, 8'h13, "R11");
    acc('hFD00, 1, 0, 0, 8'h14, "R11");
    // reset after a page change
    acc('h3FFE, 1, 0, 0, 8'h00, "R3");
    idle();
    rst_n = 1'b0; mbank = 0;
    @(negedge clk); rst_n = 1'b1;
    acc('h3ABC, 1, 0, 0, 8'h15, "R6");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int a, kind;
      bit r, w;
      case ($urandom % 4)
        0: a = int'($urandom % 65536);
        1: a = 'h3FF0 + int'($urandom % 16);
        2: a = 'h3000 + int'($urandom % 4096);
        default: a = 'hFC00 + int'($urandom % 256);
      endcase
      kind = int'($urandom % 4);
      r = (kind == 1 || kind == 2);
      w = (kind == 3);
      acc(a, r, w, ($urandom % 5) == 0, 8'($urandom), "R2");
    end
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule